// File: doc/BRIEF.md
# Skewed Majority-Vote Hybrid Branch Direction Predictor

This block predicts the direction of a conditional branch from its program counter and a global history of recent outcomes. It keeps four tables of two-bit counters: a bimodal table indexed by PC alone, two history-hashed tables, and a chooser. The bimodal table serves twice: its bit can be the final answer on its own, and it is also one voter in a three-way majority with the two history tables. The chooser table decides, per lookup, which of these two answers is returned. Every counter is held as a direction bit in one array and a confidence (hysteresis) bit in a separate array.

A lookup is presented on a valid/ready request port. One cycle after acceptance the response carries the final direction, the two candidate answers, the chooser's decision and the four table indices. When the branch resolves, the front end returns the outcome together with those four indices on the update port. The update port is always ready and wins over lookups: while an update is presented, the request port drops ready. The response port has no back-pressure: the consumer must take the response in the cycle that `rsp_valid` is high.

Top module: `skew_vote_predictor`

## Requirements
- R1: `req_ready` is high exactly when `upd_valid` is low, and `upd_ready` is always high; a request accepted at a clock edge (`req_valid` and `req_ready` high) raises `rsp_valid` for exactly the following cycle, and `rsp_valid` is low in any cycle not preceded by an accepted request.
- R2: With p = `req_pc[PC_LSB +: N]` for an N-bit index and f the N-bit fold of the history (history bit i is XORed into fold bit i mod N), the indices are: bimodal = p, first history table = p ^ f, second history table = p ^ rotl1(f) where rotl1 moves bit N-1 to bit 0 and every other bit up by one, chooser = bitreverse(p) ^ f.
- R3: After reset every counter in every table holds direction 0 (not taken) with weak confidence, so the chooser selects the bimodal answer, and `rsp_valid` is low.
- R4: `rsp_vote_taken` is the majority of the bimodal bit and the two history-table bits; `rsp_taken` equals `rsp_vote_taken` when the chooser bit is 1 (`rsp_use_vote` high) and `rsp_bim_taken` otherwise.
- R5: Training a counter toward an outcome: if its direction bit already equals the outcome, confidence becomes strong; if it differs and confidence is strong, only confidence drops to weak; if it differs and confidence is weak, the direction bit takes the outcome and confidence stays weak.
- R6: On an update the chooser counter is trained only if the bimodal bit and the majority vote (read at the supplied indices) differ, toward 1 when the vote equals the outcome and toward 0 otherwise; when they agree the chooser is left unchanged.
- R7: When the final answer recomputed at the supplied indices equals the outcome, only those of the bimodal and two history tables whose bit equals the outcome are trained; the others are left unchanged.
- R8: When the recomputed final answer differs from the outcome, the bimodal and both history tables are all trained toward the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted (low while an update is presented) |
| req_pc | input | PC_W | Branch program counter |
| req_hist | input | HIST_W | Global outcome history |
| rsp_valid | output | 1 | Response present for one cycle, no back-pressure |
| rsp_taken | output | 1 | Final predicted direction |
| rsp_use_vote | output | 1 | Chooser picked the majority vote |
| rsp_bim_taken | output | 1 | Bimodal table direction |
| rsp_vote_taken | output | 1 | Majority of bimodal and both history tables |
| rsp_bim_idx | output | BIM_IDX_W | Bimodal table index used |
| rsp_g0_idx | output | GLB_IDX_W | First history table index used |
| rsp_g1_idx | output | GLB_IDX_W | Second history table index used |
| rsp_meta_idx | output | META_IDX_W | Chooser table index used |
| upd_valid | input | 1 | Resolved branch update present |
| upd_ready | output | 1 | Always high |
| upd_taken | input | 1 | Resolved direction |
| upd_bim_idx | input | BIM_IDX_W | Saved bimodal index |
| upd_g0_idx | input | GLB_IDX_W | Saved first history table index |
| upd_g1_idx | input | GLB_IDX_W | Saved second history table index |
| upd_meta_idx | input | META_IDX_W | Saved chooser index |

## Verification
The hardest state to reach is one where the bimodal counter disagrees with both history tables at the same lookup, because with a neutral history all three tables share an index and train in lockstep. The stimulus first trains the two history tables through a second PC and history pair chosen so that its history-table indices collide with those of the target branch while its bimodal entry does not, then returns to the target branch with a non-zero history. That sequence moves the chooser toward the vote and back, and shows that a disagreeing bimodal counter is left alone after a correct vote and retrained after a wrong one.

// File: rtl/sk_pkg.sv
package sk_pkg;

  // Which table a hash unit feeds; selects the index function.
  typedef enum logic [1:0] {
    TBL_BIM  = 2'd0,
    TBL_G0   = 2'd1,
    TBL_G1   = 2'd2,
    TBL_META = 2'd3
  } sk_table_e;

  // Two-bit counter held as a direction bit and a confidence bit.
  typedef struct packed {
    logic pred;
    logic hyst;
  } sk_ctr_t;

  // Move a counter one step toward dir (R5).
  function automatic sk_ctr_t ctr_train(sk_ctr_t c, logic dir);
    sk_ctr_t n;
    n = c;
    if (c.pred == dir)  n.hyst = 1'b1;
    else if (c.hyst)    n.hyst = 1'b0;
    else                n.pred = dir;
    return n;
  endfunction

  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/sk_index_hash.sv
module sk_index_hash
  import sk_pkg::*;
#(
  parameter int        PC_W   = 32,
  parameter int        HIST_W = 12,
  parameter int        PC_LSB = 2,
  parameter int        IDX_W  = 6,
  parameter sk_table_e KIND   = TBL_BIM
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] pc_slice;
  logic [IDX_W-1:0] hfold;
  logic [IDX_W-1:0] hrot;
  logic [IDX_W-1:0] pc_rev;
  logic             unused_in;

  assign unused_in = ^{pc, hist};
  assign pc_slice  = pc[PC_LSB +: IDX_W];

  always_comb begin
    hfold = '0;
    for (int i = 0; i < HIST_W; i++) begin
      hfold[i % IDX_W] = hfold[i % IDX_W] ^ hist[i];
    end
  end

  always_comb begin
    for (int i = 0; i < IDX_W; i++) begin
      pc_rev[i] = pc_slice[IDX_W-1-i];
    end
  end

  assign hrot = {hfold[IDX_W-2:0], hfold[IDX_W-1]};

  generate
    if (KIND == TBL_BIM) begin : g_bim
      assign idx = pc_slice;
    end else if (KIND == TBL_G0) begin : g_g0
      assign idx = pc_slice ^ hfold;
    end else if (KIND == TBL_G1) begin : g_g1
      assign idx = pc_slice ^ hrot;
    end else begin : g_meta
      assign idx = pc_rev ^ hfold;
    end
  endgenerate

  initial begin
    if (IDX_W < 2) $error("sk_index_hash: IDX_W must be at least 2");
  end

endmodule

// File: rtl/sk_ctr_bank.sv
module sk_ctr_bank
  import sk_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output sk_ctr_t          rd_ctr,
  input  logic [IDX_W-1:0] upd_idx,
  output sk_ctr_t          upd_cur,
  input  logic             upd_en,
  input  logic             upd_dir
);

  localparam int DEPTH = 1 << IDX_W;

  // Direction bits and confidence bits kept in separate arrays.
  logic [DEPTH-1:0] pbits;
  logic [DEPTH-1:0] hbits;
  sk_ctr_t          nxt;

  assign rd_ctr  = '{pred: pbits[rd_idx],  hyst: hbits[rd_idx]};
  assign upd_cur = '{pred: pbits[upd_idx], hyst: hbits[upd_idx]};
  assign nxt     = ctr_train(upd_cur, upd_dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbits <= '0;
      hbits <= '0;
    end else if (upd_en) begin
      pbits[upd_idx] <= nxt.pred;
      hbits[upd_idx] <= nxt.hyst;
    end
  end

  // R5: agreeing counter ends strong with its direction kept
  a_r5_strengthen: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (upd_cur.pred == upd_dir)
    |=> hbits[$past(upd_idx)] && (pbits[$past(upd_idx)] == $past(upd_dir)));

  // R5: strong disagreeing counter only loses confidence
  a_r5_weaken: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (upd_cur.pred != upd_dir) && upd_cur.hyst
    |=> !hbits[$past(upd_idx)] && (pbits[$past(upd_idx)] == $past(upd_cur.pred)));

  // R5: weak disagreeing counter flips direction and stays weak
  a_r5_flip: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (upd_cur.pred != upd_dir) && !upd_cur.hyst
    |=> !hbits[$past(upd_idx)] && (pbits[$past(upd_idx)] == $past(upd_dir)));

endmodule

// File: rtl/skew_vote_predictor.sv
module skew_vote_predictor
  import sk_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int HIST_W     = 12,
  parameter int PC_LSB     = 2,
  parameter int BIM_IDX_W  = 6,
  parameter int GLB_IDX_W  = 6,
  parameter int META_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PC_W-1:0]       req_pc,
  input  logic [HIST_W-1:0]     req_hist,
  output logic                  rsp_valid,
  output logic                  rsp_taken,
  output logic                  rsp_use_vote,
  output logic                  rsp_bim_taken,
  output logic                  rsp_vote_taken,
  output logic [BIM_IDX_W-1:0]  rsp_bim_idx,
  output logic [GLB_IDX_W-1:0]  rsp_g0_idx,
  output logic [GLB_IDX_W-1:0]  rsp_g1_idx,
  output logic [META_IDX_W-1:0] rsp_meta_idx,
  input  logic                  upd_valid,
  output logic                  upd_ready,
  input  logic                  upd_taken,
  input  logic [BIM_IDX_W-1:0]  upd_bim_idx,
  input  logic [GLB_IDX_W-1:0]  upd_g0_idx,
  input  logic [GLB_IDX_W-1:0]  upd_g1_idx,
  input  logic [META_IDX_W-1:0] upd_meta_idx
);

  // ---------------- index generation ----------------
  logic [BIM_IDX_W-1:0]  l_bim_idx;
  logic [GLB_IDX_W-1:0]  l_g0_idx;
  logic [GLB_IDX_W-1:0]  l_g1_idx;
  logic [META_IDX_W-1:0] l_meta_idx;

  sk_index_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB),
                  .IDX_W(BIM_IDX_W), .KIND(TBL_BIM))
    u_hash_bim  (.pc(req_pc), .hist(req_hist), .idx(l_bim_idx));
  sk_index_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB),
                  .IDX_W(GLB_IDX_W), .KIND(TBL_G0))
    u_hash_g0   (.pc(req_pc), .hist(req_hist), .idx(l_g0_idx));
  sk_index_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB),
                  .IDX_W(GLB_IDX_W), .KIND(TBL_G1))
    u_hash_g1   (.pc(req_pc), .hist(req_hist), .idx(l_g1_idx));
  sk_index_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB),
                  .IDX_W(META_IDX_W), .KIND(TBL_META))
    u_hash_meta (.pc(req_pc), .hist(req_hist), .idx(l_meta_idx));

  // ---------------- update decision ----------------
  sk_ctr_t l_bim, l_g0, l_g1, l_meta;   // lookup reads
  sk_ctr_t u_bim, u_g0, u_g1, u_meta;   // reads at saved indices
  logic    u_vote, u_final, u_correct;
  logic    en_bim, en_g0, en_g1, en_meta, dir_meta;

  assign u_vote    = maj3(u_bim.pred, u_g0.pred, u_g1.pred);
  assign u_final   = u_meta.pred ? u_vote : u_bim.pred;
  assign u_correct = (u_final == upd_taken);

  // Correct: train only agreeing voters. Wrong: train all voters.
  assign en_bim   = upd_valid && (!u_correct || (u_bim.pred == upd_taken));
  assign en_g0    = upd_valid && (!u_correct || (u_g0.pred  == upd_taken));
  assign en_g1    = upd_valid && (!u_correct || (u_g1.pred  == upd_taken));
  // Chooser trains only when its two candidates disagree.
  assign en_meta  = upd_valid && (u_bim.pred != u_vote);
  assign dir_meta = (u_vote == upd_taken);

  // ---------------- counter tables ----------------
  sk_ctr_bank #(.IDX_W(BIM_IDX_W)) u_bank_bim (
    .clk(clk), .rst_n(rst_n), .rd_idx(l_bim_idx), .rd_ctr(l_bim),
    .upd_idx(upd_bim_idx), .upd_cur(u_bim), .upd_en(en_bim), .upd_dir(upd_taken));
  sk_ctr_bank #(.IDX_W(GLB_IDX_W)) u_bank_g0 (
    .clk(clk), .rst_n(rst_n), .rd_idx(l_g0_idx), .rd_ctr(l_g0),
    .upd_idx(upd_g0_idx), .upd_cur(u_g0), .upd_en(en_g0), .upd_dir(upd_taken));
  sk_ctr_bank #(.IDX_W(GLB_IDX_W)) u_bank_g1 (
    .clk(clk), .rst_n(rst_n), .rd_idx(l_g1_idx), .rd_ctr(l_g1),
    .upd_idx(upd_g1_idx), .upd_cur(u_g1), .upd_en(en_g1), .upd_dir(upd_taken));
  sk_ctr_bank #(.IDX_W(META_IDX_W)) u_bank_meta (
    .clk(clk), .rst_n(rst_n), .rd_idx(l_meta_idx), .rd_ctr(l_meta),
    .upd_idx(upd_meta_idx), .upd_cur(u_meta), .upd_en(en_meta), .upd_dir(dir_meta));

  // ---------------- lookup handshake and response ----------------
  logic req_fire;
  logic l_vote;

  assign upd_ready = 1'b1;
  assign req_ready = !upd_valid;
  assign req_fire  = req_valid && req_ready;
  assign l_vote    = maj3(l_bim.pred, l_g0.pred, l_g1.pred);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_taken      <= 1'b0;
      rsp_use_vote   <= 1'b0;
      rsp_bim_taken  <= 1'b0;
      rsp_vote_taken <= 1'b0;
      rsp_bim_idx    <= '0;
      rsp_g0_idx     <= '0;
      rsp_g1_idx     <= '0;
      rsp_meta_idx   <= '0;
    end else begin
      rsp_valid <= req_fire;
      if (req_fire) begin
        rsp_taken      <= l_meta.pred ? l_vote : l_bim.pred;
        rsp_use_vote   <= l_meta.pred;
        rsp_bim_taken  <= l_bim.pred;
        rsp_vote_taken <= l_vote;
        rsp_bim_idx    <= l_bim_idx;
        rsp_g0_idx     <= l_g0_idx;
        rsp_g1_idx     <= l_g1_idx;
        rsp_meta_idx   <= l_meta_idx;
      end
    end
  end

  // R1: a response only follows an accepted request
  a_r1_rsp_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !upd_valid));

  // R1: an accepted request always produces a response
  a_r1_fire_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !upd_valid |=> rsp_valid);

endmodule

// File: tb/tb_skew_vote_predictor.sv
`timescale 1ns/1ps
module tb_skew_vote_predictor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pc = '0;
  logic [11:0] req_hist = '0;
  logic        rsp_valid, rsp_taken, rsp_use_vote, rsp_bim_taken, rsp_vote_taken;
  logic [5:0]  rsp_bim_idx, rsp_g0_idx, rsp_g1_idx, rsp_meta_idx;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic        upd_taken = 1'b0;
  logic [5:0]  upd_bim_idx = '0, upd_g0_idx = '0, upd_g1_idx = '0, upd_meta_idx = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  skew_vote_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc), .req_hist(req_hist),
    .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_use_vote(rsp_use_vote),
    .rsp_bim_taken(rsp_bim_taken), .rsp_vote_taken(rsp_vote_taken),
    .rsp_bim_idx(rsp_bim_idx), .rsp_g0_idx(rsp_g0_idx), .rsp_g1_idx(rsp_g1_idx),
    .rsp_meta_idx(rsp_meta_idx),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_taken(upd_taken),
    .upd_bim_idx(upd_bim_idx), .upd_g0_idx(upd_g0_idx), .upd_g1_idx(upd_g1_idx),
    .upd_meta_idx(upd_meta_idx)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [11:0] hist;
    logic        outcome;
    logic        e_bim;
    logic        e_vote;
    logic        e_fin;
    logic [5:0]  i_bim;
    logic [5:0]  i_g0;
    logic [5:0]  i_g1;
    logic [5:0]  i_meta;
  } vec_t;

  localparam int NVEC = 12;
  // Lookup, check, then update with the returned indices and outcome.
  localparam vec_t VECS [NVEC] = '{
    '{32'h14, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 6'd5,  6'd5, 6'd5, 6'd40}, // R3 R8
    '{32'h14, 12'h000, 1'b1, 1'b1, 1'b1, 1'b1, 6'd5,  6'd5, 6'd5, 6'd40}, // R5 flip seen
    '{32'h14, 12'h000, 1'b0, 1'b1, 1'b1, 1'b1, 6'd5,  6'd5, 6'd5, 6'd40}, // R7 strengthened
    '{32'h14, 12'h000, 1'b0, 1'b1, 1'b1, 1'b1, 6'd5,  6'd5, 6'd5, 6'd40}, // R5 weakened only
    '{32'h14, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5,  6'd5, 6'd5, 6'd40}, // R5 flipped
    '{32'hE8, 12'h03E, 1'b1, 1'b0, 1'b0, 1'b0, 6'd58, 6'd4, 6'd7, 6'd41}, // R8
    '{32'hE8, 12'h03E, 1'b1, 1'b1, 1'b1, 1'b1, 6'd58, 6'd4, 6'd7, 6'd41}, // R8
    '{32'h14, 12'h001, 1'b1, 1'b0, 1'b1, 1'b0, 6'd5,  6'd4, 6'd7, 6'd41}, // R4 R6
    '{32'h14, 12'h001, 1'b1, 1'b0, 1'b1, 1'b1, 6'd5,  6'd4, 6'd7, 6'd41}, // R6 R4
    '{32'h14, 12'h001, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5,  6'd4, 6'd7, 6'd41}, // R7
    '{32'h14, 12'h001, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5,  6'd4, 6'd7, 6'd41}, // R6 R8
    '{32'h14, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5,  6'd4, 6'd7, 6'd41}  // R6 R8
  };

  function automatic string tag_of(int k);
    case (k)
      0:       return "R3 R8";
      1, 3, 4: return "R5";
      2:       return "R7";
      5, 6:    return "R8";
      7:       return "R4 R6";
      8:       return "R6 R7";
      9:       return "R7 R8";
      default: return "R6 R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Accepted at the next posedge; response sampled at the following negedge.
  task automatic lookup(input logic [31:0] pc, input logic [11:0] hist);
    @(negedge clk);
    req_valid = 1'b1;
    req_pc    = pc;
    req_hist  = hist;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic update(input logic t, input logic [5:0] ib, input logic [5:0] i0,
                        input logic [5:0] i1, input logic [5:0] im);
    @(negedge clk);
    upd_valid    = 1'b1;
    upd_taken    = t;
    upd_bim_idx  = ib;
    upd_g0_idx   = i0;
    upd_g1_idx   = i1;
    upd_meta_idx = im;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R1: idle outputs after reset
    chk("R3", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1", "upd_ready", {31'b0, upd_ready}, 32'd1);

    // Vector walk
    for (int k = 0; k < NVEC; k++) begin
      lookup(VECS[k].pc, VECS[k].hist);
      chk("R1", "rsp_valid", {31'b0, rsp_valid},      32'd1);
      chk("R2", "bim_idx",   {26'b0, rsp_bim_idx},    {26'b0, VECS[k].i_bim});
      chk("R2", "g0_idx",    {26'b0, rsp_g0_idx},     {26'b0, VECS[k].i_g0});
      chk("R2", "g1_idx",    {26'b0, rsp_g1_idx},     {26'b0, VECS[k].i_g1});
      chk("R2", "meta_idx",  {26'b0, rsp_meta_idx},   {26'b0, VECS[k].i_meta});
      chk(tag_of(k), "bim_taken",  {31'b0, rsp_bim_taken},  {31'b0, VECS[k].e_bim});
      chk(tag_of(k), "vote_taken", {31'b0, rsp_vote_taken}, {31'b0, VECS[k].e_vote});
      chk(tag_of(k), "taken",      {31'b0, rsp_taken},      {31'b0, VECS[k].e_fin});
      update(VECS[k].outcome, rsp_bim_idx, rsp_g0_idx, rsp_g1_idx, rsp_meta_idx);
    end

    // R1: single-cycle response pulse
    chk("R1", "rsp_valid drop", {31'b0, rsp_valid}, 32'd0);

    // R1: update holds off a lookup
    @(negedge clk);
    upd_valid = 1'b1; upd_taken = 1'b0;
    upd_bim_idx = 6'd63; upd_g0_idx = 6'd63; upd_g1_idx = 6'd63; upd_meta_idx = 6'd63;
    req_valid = 1'b1; req_pc = 32'h14; req_hist = 12'h000;
    #1;
    chk("R1", "req_ready under update", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R1", "no rsp while blocked", {31'b0, rsp_valid}, 32'd0);
    upd_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "rsp after release", {31'b0, rsp_valid}, 32'd1);

    // R2: history bits above the index width fold back in
    lookup(32'h14, 12'h040);
    chk("R2", "fold g0",   {26'b0, rsp_g0_idx},   32'd4);
    chk("R2", "fold g1",   {26'b0, rsp_g1_idx},   32'd7);
    chk("R2", "fold meta", {26'b0, rsp_meta_idx}, 32'd41);
    lookup(32'h14, 12'h041);
    chk("R2", "fold cancel", {26'b0, rsp_g0_idx}, 32'd5);

    // R3: a second reset clears trained entries
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R3", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    lookup(32'hE8, 12'h03E);
    chk("R3", "bim after reset",  {31'b0, rsp_bim_taken},  32'd0);
    chk("R3", "vote after reset", {31'b0, rsp_vote_taken}, 32'd0);
    chk("R3", "chooser after reset", {31'b0, rsp_use_vote}, 32'd0);

    done = 1'b1;
    summary();
  end

endmodule